// File: doc/BRIEF.md
# Time-Base Timer with Clock Output

An 8-bit up-counter whose count enable comes from one of two free-running prescalers. In interval mode it advances on taps of a prescaler clocked by the system clock. In time-base mode it advances on taps of a second prescaler, and that prescaler steps on each rising edge of an asynchronous sub-clock. The sub-clock is first brought into the system-clock domain. When the counter wraps it sets a sticky overflow flag, which also serves as the interrupt request. In time-base mode, a single register write clears both the counter and the sub-clock prescaler, so software can restart the period from a known phase.

The same prescalers feed a clock-output selector. It offers four divided system clocks, four divided sub-clocks and the undivided sub-clock. A pin-enable bit gates the selection, and a power-mode input decides which of the choices are valid. The block is controlled through a simple write/read register port. The mode-select bit can only be changed while the module clock-run bit is set.

Top module: `tbt_timer`

## Requirements
- R1: After reset, every register field reads 0, the counter and both prescalers are 0, and `irq` and `clk_out` are low.
- R2: The register map is as follows. Address 0 is the mode register: bits [7:5] output select, bit 4 extra select, bit 3 time-base mode, bit 2 clear (write-only, reads 0), bits [1:0] period code p. Address 1 bit 0 is clock-run. Address 2 bit 0 is pin enable. Address 3 bit 0 is the overflow flag. Address 4 is the counter (read-only). `rdata` shows the addressed register combinationally.
- R3: While clock-run is 0, writes leave the time-base mode bit unchanged. Other mode-register fields are still written.
- R4: In interval mode with clock-run 1, the counter advances once every 2^(6-p) system clocks.
- R5: In time-base mode with clock-run 1, the counter advances once every 2^(7-p) sub-clock rising edges. Each edge is seen through a two-flop synchronizer with an edge detector.
- R6: In time-base mode, writing the clear bit as 1 sets the counter and the sub-clock prescaler to 0. In interval mode, the clear bit has no effect.
- R7: While clock-run is 0, the counter holds its value.
- R8: When the counter steps from 0xFF to 0x00, the overflow flag is set and `irq` goes high. The flag stays set until 0 is written to address 3 bit 0.
- R9: The output source is chosen as follows. With extra select 1, the source is the undivided sub-clock. With extra select 0, select bit 7 picks the system clock (0) or the sub-clock (1), and bits [6:5] = 00, 01, 10, 11 give divide by 32, 16, 8, 4.
- R10: Power-mode codes are 0 active, 1 sleep, 2 watch, 3 subactive, 4 subsleep, and 5 or above standby. Divided system clocks are valid only in codes 0 to 1. Divided sub-clocks are valid only in codes 0 to 4. The undivided sub-clock is valid in every code. An invalid choice drives `clk_out` low.
- R11: `clk_out` is low whenever pin enable is 0. It is registered, one system clock after its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_clk | input | 1 | Asynchronous sub-clock |
| pwr_mode | input | 3 | Current power mode code |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of addressed register |
| irq | output | 1 | Overflow interrupt request |
| clk_out | output | 1 | Selected clock output |

## Verification
The assertions assume one register access per cycle, so a clock-run change and a mode write never land on the same edge. They also assume the sub-clock is slow enough that the synchronizer sees each level for at least two system clocks. The bench drives the sub-clock with a period of eight system clocks, exactly aligned, and issues writes one at a time. Every rate it measures therefore comes out as an exact count over its window, apart from the stated phase tolerance on clock-output edges.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
    localparam int CNT_W = 8;
    localparam int PSC_W = 8;
    localparam int DAT_W = 8;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_RUN  = 3'd1;
    localparam logic [2:0] A_PIN  = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_CNT  = 3'd4;

    localparam logic [2:0] PM_SLEEP  = 3'd1;
    localparam logic [2:0] PM_SUBSLP = 3'd4;

    typedef struct packed {
        logic [2:0]       out_sel;
        logic             ext_sel;
        logic             tb_mode;
        logic [1:0]       period;
        logic             clk_run;
        logic             pin_en;
        logic             ovf;
        logic [CNT_W-1:0] cnt;
    } regs_t;
endpackage

// File: rtl/tbt_sync.sv
module tbt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tbt_prescale.sv
module tbt_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         clr,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr)      val_d = '0;
        else if (adv) val_d = val_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/tbt_clkmux.sv
module tbt_clkmux
    import tbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_en,
    input  logic       ext_sel,
    input  logic [2:0] sel,
    input  logic [2:0] pwr_mode,
    input  logic [3:0] sys_taps,
    input  logic [3:0] sub_taps,
    input  logic       sub_level,
    output logic       clk_out
);
    logic       out_d, out_q;
    logic [1:0] idx;
    logic       src, valid;

    always_comb begin
        idx = ~sel[1:0];
        if (ext_sel) begin
            src   = sub_level;
            valid = 1'b1;
        end else if (sel[2]) begin
            src   = sub_taps[idx];
            valid = (pwr_mode <= PM_SUBSLP);
        end else begin
            src   = sys_taps[idx];
            valid = (pwr_mode <= PM_SLEEP);
        end
        out_d = pin_en & valid & src;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= out_d;
    end

    assign clk_out = out_q;
endmodule

// File: rtl/tbt_timer.sv
module tbt_timer
    import tbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sub_clk,
    input  logic [2:0]       pwr_mode,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [DAT_W-1:0] wdata,
    output logic [DAT_W-1:0] rdata,
    output logic             irq,
    output logic             clk_out
);
    regs_t r_d, r_q;

    logic             sub_level, sub_tick;
    logic [PSC_W-1:0] psc_sys, psc_sub, mask;
    logic [2:0]       shift;
    logic             tb_clr, tick_int, tick_tb, cnt_tick;

    // Signals named for the bound checker
    logic             mode_w, run_w, pin_w, ext_w, pick_sub_w;
    logic [CNT_W-1:0] cnt_w;

    tbt_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .async_in(sub_clk),
        .level(sub_level), .rise(sub_tick)
    );

    tbt_prescale #(.W(PSC_W)) u_psc_sys (
        .clk(clk), .rst(rst), .adv(1'b1), .clr(1'b0), .value(psc_sys)
    );

    tbt_prescale #(.W(PSC_W)) u_psc_sub (
        .clk(clk), .rst(rst), .adv(sub_tick), .clr(tb_clr), .value(psc_sub)
    );

    tbt_clkmux u_mux (
        .clk(clk), .rst(rst), .pin_en(r_q.pin_en), .ext_sel(r_q.ext_sel),
        .sel(r_q.out_sel), .pwr_mode(pwr_mode),
        .sys_taps(psc_sys[4:1]), .sub_taps(psc_sub[4:1]),
        .sub_level(sub_level), .clk_out(clk_out)
    );

    always_comb begin
        tb_clr   = wr_en && (addr == A_MODE) && wdata[2] && r_q.tb_mode;
        shift    = r_q.tb_mode ? (3'd7 - {1'b0, r_q.period})
                               : (3'd6 - {1'b0, r_q.period});
        mask     = (PSC_W'(1) << shift) - PSC_W'(1);
        tick_int = ((psc_sys & mask) == mask);
        tick_tb  = sub_tick && ((psc_sub & mask) == mask);
        cnt_tick = r_q.clk_run && (r_q.tb_mode ? tick_tb : tick_int);
    end

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_MODE: begin
                    r_d.out_sel = wdata[7:5];
                    r_d.ext_sel = wdata[4];
                    r_d.period  = wdata[1:0];
                    if (r_q.clk_run) r_d.tb_mode = wdata[3];
                end
                A_RUN:  r_d.clk_run = wdata[0];
                A_PIN:  r_d.pin_en  = wdata[0];
                A_STAT: if (!wdata[0]) r_d.ovf = 1'b0;
                default: ;
            endcase
        end
        if (tb_clr) begin
            r_d.cnt = '0;
        end else if (cnt_tick) begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
            if (&r_q.cnt) r_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_MODE:  rdata = {r_q.out_sel, r_q.ext_sel, r_q.tb_mode, 1'b0, r_q.period};
            A_RUN:   rdata = {7'd0, r_q.clk_run};
            A_PIN:   rdata = {7'd0, r_q.pin_en};
            A_STAT:  rdata = {7'd0, r_q.ovf};
            A_CNT:   rdata = r_q.cnt;
            default: rdata = '0;
        endcase
    end

    assign irq        = r_q.ovf;
    assign mode_w     = r_q.tb_mode;
    assign run_w      = r_q.clk_run;
    assign pin_w      = r_q.pin_en;
    assign ext_w      = r_q.ext_sel;
    assign pick_sub_w = r_q.out_sel[2];
    assign cnt_w      = r_q.cnt;
endmodule

// File: rtl/tbt_timer_chk.sv
module tbt_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic       clr_bit,
    input logic [2:0] pwr_mode,
    input logic       mode_w,
    input logic       run_w,
    input logic       pin_w,
    input logic       ext_w,
    input logic       pick_sub_w,
    input logic [7:0] cnt_w,
    input logic       irq,
    input logic       clk_out
);
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !run_w |=> $stable(mode_w)) else $error("mode bit changed while locked"); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_w != $past(cnt_w)) |-> (cnt_w == $past(cnt_w) + 8'd1 || cnt_w == 8'd0))
        else $error("counter jumped"); // R4

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_w && !(wr_en && addr == 3'd0 && clr_bit && mode_w)) |=> $stable(cnt_w))
        else $error("counter moved while halted"); // R7

    AST_TB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && clr_bit && mode_w) |=> (cnt_w == 8'd0))
        else $error("time-base clear missed"); // R6

    AST_IRQ_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt_w == 8'd0)) else $error("flag raised off wrap"); // R8

    AST_PIN_GATE: assert property (@(posedge clk) disable iff (rst)
        !pin_w |=> !clk_out) else $error("output driven while disabled"); // R11

    AST_SYS_MODE_VALID: assert property (@(posedge clk) disable iff (rst)
        (!ext_w && !pick_sub_w && pwr_mode >= 3'd2) |=> !clk_out)
        else $error("system clock output in low-power mode"); // R10
endmodule

bind tbt_timer tbt_timer_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .clr_bit(wdata[2]),
    .pwr_mode(pwr_mode), .mode_w(mode_w), .run_w(run_w), .pin_w(pin_w),
    .ext_w(ext_w), .pick_sub_w(pick_sub_w), .cnt_w(cnt_w),
    .irq(irq), .clk_out(clk_out)
);

// File: tb/tbt_timer_test.sv
module tbt_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sub_clk = 1'b0;
    logic [2:0] pwr_mode = 3'd0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, clk_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    tbt_timer uut (
        .clk(clk), .rst(rst), .sub_clk(sub_clk), .pwr_mode(pwr_mode),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .clk_out(clk_out)
    );

    always #5 clk = ~clk;
    always #40 sub_clk = ~sub_clk;

    // {ext, sel[2:0], pwr[2:0], en, expected rising edges in 320 cycles}
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 3'd3, 3'd0, 1'b1, 8'd80},
        {1'b0, 3'd0, 3'd1, 1'b1, 8'd10},
        {1'b0, 3'd7, 3'd2, 1'b1, 8'd10},
        {1'b0, 3'd5, 3'd0, 1'b1, 8'd2},
        {1'b1, 3'd0, 3'd5, 1'b1, 8'd40},
        {1'b0, 3'd3, 3'd3, 1'b1, 8'd0},
        {1'b0, 3'd3, 3'd0, 1'b0, 8'd0},
        {1'b0, 3'd6, 3'd5, 1'b1, 8'd0},
        {1'b0, 3'd2, 3'd0, 1'b1, 8'd40}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rate(input logic [7:0] mode, input int win, input int exp, input string req);
        logic [7:0] c0, c1;
        wr(3'd0, mode);
        rd(3'd4, c0);
        wait_cyc(win);
        rd(3'd4, c1);
        check(8'(c1 - c0) == 8'(exp), req, int'(8'(c1 - c0)), exp);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, c, c2;
        int edges;
        logic prev;
        bit seen;

        wait_cyc(5);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check(v == 8'd0, "R1 register", v, 0);
        end

        // R9 R10 R11: clock-output table
        for (int i = 0; i < NV; i++) begin
            wr(3'd2, {7'd0, VEC[i][8]});
            wr(3'd0, {VEC[i][14:12], VEC[i][15], 4'd0});
            pwr_mode = VEC[i][11:9];
            wait_cyc(40);
            edges = 0;
            prev = clk_out;
            for (int k = 0; k < 320; k++) begin
                @(negedge clk);
                if (clk_out && !prev) edges++;
                prev = clk_out;
            end
            check((edges >= int'(VEC[i][7:0]) - 1) && (edges <= int'(VEC[i][7:0]) + 1),
                  "R9/R10/R11 clock output", edges, int'(VEC[i][7:0]));
        end
        pwr_mode = 3'd0;
        wr(3'd2, 8'd0);

        // R3: mode bit locked while clock-run is 0
        wr(3'd0, 8'h08);
        rd(3'd0, v);
        check(v == 8'h00, "R3 locked mode", v, 8'h00);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h0F);
        rd(3'd0, v);
        check(v == 8'h0B, "R2 R3 mode readback", v, 8'h0B);

        // R5: time-base rates
        rate(8'h0B, 384, 3, "R5 period code 3");
        rate(8'h0A, 768, 3, "R5 period code 2");

        // R6: time-base clear resets counter and prescaler
        wr(3'd0, 8'h0B);
        wait_cyc(200);
        wr(3'd0, 8'h0F);
        rd(3'd4, v);
        check(v == 8'd0, "R6 cleared", v, 0);
        wait_cyc(110);
        rd(3'd4, v);
        check(v == 8'd0, "R6 prescaler phase early", v, 0);
        wait_cyc(30);
        rd(3'd4, v);
        check(v == 8'd1, "R6 prescaler phase late", v, 1);

        // R4: interval rates
        rate(8'h03, 80, 10, "R4 period code 3");
        rate(8'h00, 640, 10, "R4 period code 0");

        // R6: clear ignored in interval mode
        wr(3'd0, 8'h03);
        wait_cyc(50);
        rd(3'd4, c);
        wr(3'd0, 8'h07);
        rd(3'd4, c2);
        check((c2 == c) || (c2 == 8'(c + 8'd1)), "R6 clear ignored in interval", c2, c);

        // R7: halt holds counter
        wr(3'd1, 8'h00);
        rd(3'd4, c);
        wait_cyc(200);
        rd(3'd4, c2);
        check(c2 == c, "R7 halted", c2, c);

        // R8: overflow flag
        wr(3'd1, 8'h01);
        seen = 0;
        for (int k = 0; k < 2200 && !seen; k++) begin
            @(negedge clk);
            if (irq) seen = 1;
        end
        check(seen, "R8 irq raised", seen, 1);
        rd(3'd4, v);
        check(v == 8'd0, "R8 counter at wrap", v, 0);
        wait_cyc(20);
        check(irq == 1'b1, "R8 flag sticky", irq, 1);
        wr(3'd3, 8'h01);
        #1;
        check(irq == 1'b1, "R8 writing 1 keeps flag", irq, 1);
        wr(3'd3, 8'h00);
        #1;
        check(irq == 1'b0, "R8 flag cleared", irq, 0);
        rd(3'd3, v);
        check(v == 8'd0, "R2 status readback", v, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule